// File: doc/BRIEF.md
# Preemptive Graphics Memory Arbiter

This block places up to five requesting engines in front of one single-port word memory. Each requester presents an operation code, write data, a base address and a set of rectangle fields: its current horizontal and vertical offsets, the width of the whole image in words, and the width and height of the rectangle being walked. Every cycle the block grants one word to the active requester with the highest fixed priority. It computes the linear word address and performs the access. A request from a higher-priority engine takes the bus at the next word, even in the middle of a lower-priority burst.

Requesters hold their own offset counters and advance them on every word acknowledge. A burst that was interrupted, whether by a higher-priority engine or by a memory refresh, therefore resumes from exactly the word it stopped at. A completion strobe marks the last word of a rectangle. In this block the memory device is a simple synchronous word array, and a refresh-busy input stalls all traffic.

Top module: `gfx_mem_arbiter`

## Requirements
- R1: After reset, `bus_gnt`, `rd_valid`, `word_ack` and `word_done` are all zero while no request is present.
- R2: Operation codes are 0 = none, 1 = single read, 2 = single write, 3 = burst read, 4 = burst write. Codes 5 to 15 count as no request and are never acknowledged.
- R3: In a cycle with no refresh, `word_ack` is one-hot on the lowest-numbered port with a valid operation (port 0 has the highest priority), and zero when no port requests.
- R4: A burst word is accessed at base + hcnt + vcnt × image_width, taken modulo 2^ADDR_W. The memory is indexed by the low MEM_AW bits of that address.
- R5: A single access uses the base address directly. Its offset, image-width, rectangle-width and rectangle-height fields have no effect.
- R6: An acknowledged read word appears on `rd_data`, with the reader's `rd_valid` bit set, one clock edge after the acknowledge cycle.
- R7: While `refresh_busy` is 1, no word is acknowledged, memory contents are not changed and `bus_gnt` holds its value.
- R8: After an acknowledged burst word that is not the last one, `bus_gnt` is one-hot on that port from the next edge. When a different port takes a word, the old grant bit falls and the new one rises on the same edge. After a last word, `bus_gnt` returns to zero.
- R9: `word_done` pulses together with `word_ack` on every single access, and on the burst word where hcnt = rect_width − 1 and vcnt = rect_height − 1.
- R10: A burst that is preempted and then resumed from the requester's own counters writes every rectangle word exactly once, with the same contents as an uninterrupted burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_busy | input | 1 | Memory refresh in progress; stalls all access |
| req_op | input | N_PORTS*4 | Operation code per port |
| req_wdata | input | N_PORTS*DATA_W | Write data per port |
| req_base | input | N_PORTS*ADDR_W | Base word address per port |
| req_hcnt | input | N_PORTS*CNT_W | Current horizontal offset per port |
| req_vcnt | input | N_PORTS*CNT_W | Current vertical offset per port |
| req_width | input | N_PORTS*CNT_W | Image width in words per port |
| req_hlen | input | N_PORTS*CNT_W | Rectangle width per port |
| req_vlen | input | N_PORTS*CNT_W | Rectangle height per port |
| word_ack | output | N_PORTS | Word accepted this cycle (advance counters) |
| word_done | output | N_PORTS | Last word of the request accepted this cycle |
| bus_gnt | output | N_PORTS | Current bus owner for an unfinished burst |
| rd_valid | output | N_PORTS | Read data valid for this port |
| rd_data | output | DATA_W | Read data |

## Verification
`word_ack` and `word_done` are combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples these two outputs one nanosecond later. Memory writes, `rd_valid`, `rd_data` and `bus_gnt` change on the next rising edge, so the bench samples them at the following falling edge. Write effects are confirmed by reading the word back through a single-read request. The preemption test steps two requester models one cycle at a time. Each cycle it predicts the grant from the previous acknowledge, and it predicts the stall from the refresh pattern.

// File: rtl/gma_pkg.sv
package gma_pkg;
   localparam int unsigned OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NONE   = 4'd0,
      OP_RD_ONE = 4'd1,
      OP_WR_ONE = 4'd2,
      OP_RD_BST = 4'd3,
      OP_WR_BST = 4'd4
   } gma_op_e;

   function automatic logic op_is_valid(input logic [OP_W-1:0] op);
      return (op == OP_RD_ONE) || (op == OP_WR_ONE) || (op == OP_RD_BST) || (op == OP_WR_BST);
   endfunction

   function automatic logic op_is_write(input logic [OP_W-1:0] op);
      return (op == OP_WR_ONE) || (op == OP_WR_BST);
   endfunction

   function automatic logic op_is_read(input logic [OP_W-1:0] op);
      return (op == OP_RD_ONE) || (op == OP_RD_BST);
   endfunction

   function automatic logic op_is_burst(input logic [OP_W-1:0] op);
      return (op == OP_RD_BST) || (op == OP_WR_BST);
   endfunction
endpackage

// File: rtl/gma_prio_pick.sv
module gma_prio_pick #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);
   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_bit
         if (i == 0) begin : g_top
            assign pick[i] = req[i];
         end else begin : g_rest
            assign pick[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate
endmodule

// File: rtl/gma_addr_gen.sv
module gma_addr_gen
   import gma_pkg::*;
#(
   parameter int unsigned ADDR_W = 23,
   parameter int unsigned CNT_W  = 16
) (
   input  logic [OP_W-1:0]   op,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  hcnt,
   input  logic [CNT_W-1:0]  vcnt,
   input  logic [CNT_W-1:0]  width,
   input  logic [CNT_W-1:0]  hlen,
   input  logic [CNT_W-1:0]  vlen,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   localparam int unsigned PROD_W = 2 * CNT_W;

   logic [PROD_W-1:0] row_prod;
   logic [ADDR_W-1:0] row_off;
   logic [ADDR_W-1:0] col_off;
   logic [CNT_W-1:0]  hlen_m1;
   logic [CNT_W-1:0]  vlen_m1;
   logic              burst;

   assign row_prod = PROD_W'(vcnt) * PROD_W'(width);

   generate
      if (PROD_W >= ADDR_W) begin : g_prod_trunc
         assign row_off = row_prod[ADDR_W-1:0];
      end else begin : g_prod_ext
         assign row_off = {{(ADDR_W-PROD_W){1'b0}}, row_prod};
      end
      if (CNT_W >= ADDR_W) begin : g_col_trunc
         assign col_off = hcnt[ADDR_W-1:0];
      end else begin : g_col_ext
         assign col_off = {{(ADDR_W-CNT_W){1'b0}}, hcnt};
      end
   endgenerate

   assign burst   = op_is_burst(op);
   assign hlen_m1 = hlen - CNT_W'(1);
   assign vlen_m1 = vlen - CNT_W'(1);

   always_comb begin
      if (burst) begin
         addr = base + col_off + row_off;
         last = (hcnt == hlen_m1) && (vcnt == vlen_m1);
      end else begin
         addr = base;
         last = 1'b1;
      end
   end
endmodule

// File: rtl/gma_mem_model.sv
module gma_mem_model #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) begin
         store[addr] <= wdata;
      end
      if (en && !we) begin
         rdata <= store[addr];
      end
   end
endmodule

// File: rtl/gfx_mem_arbiter.sv
module gfx_mem_arbiter
   import gma_pkg::*;
#(
   parameter int unsigned N_PORTS = 5,
   parameter int unsigned ADDR_W  = 23,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MEM_AW  = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        refresh_busy,
   input  logic [N_PORTS*OP_W-1:0]     req_op,
   input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
   input  logic [N_PORTS*ADDR_W-1:0]   req_base,
   input  logic [N_PORTS*CNT_W-1:0]    req_hcnt,
   input  logic [N_PORTS*CNT_W-1:0]    req_vcnt,
   input  logic [N_PORTS*CNT_W-1:0]    req_width,
   input  logic [N_PORTS*CNT_W-1:0]    req_hlen,
   input  logic [N_PORTS*CNT_W-1:0]    req_vlen,
   output logic [N_PORTS-1:0]          word_ack,
   output logic [N_PORTS-1:0]          word_done,
   output logic [N_PORTS-1:0]          bus_gnt,
   output logic [N_PORTS-1:0]          rd_valid,
   output logic [DATA_W-1:0]           rd_data
);
   generate
      if (N_PORTS < 1 || N_PORTS > 5) begin : g_bad_ports
         $error("gfx_mem_arbiter: N_PORTS must be 1 to 5");
      end
      if (MEM_AW > ADDR_W || MEM_AW < 1) begin : g_bad_mem
         $error("gfx_mem_arbiter: MEM_AW must be 1 to ADDR_W");
      end
      if (DATA_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("gfx_mem_arbiter: data and counter widths must be positive");
      end
   endgenerate

   logic [OP_W-1:0]   op_a    [N_PORTS];
   logic [DATA_W-1:0] wdat_a  [N_PORTS];
   logic [ADDR_W-1:0] base_a  [N_PORTS];
   logic [CNT_W-1:0]  hcnt_a  [N_PORTS];
   logic [CNT_W-1:0]  vcnt_a  [N_PORTS];
   logic [CNT_W-1:0]  width_a [N_PORTS];
   logic [CNT_W-1:0]  hlen_a  [N_PORTS];
   logic [CNT_W-1:0]  vlen_a  [N_PORTS];

   logic [N_PORTS-1:0] act_v;
   logic [N_PORTS-1:0] rd_mask;
   logic [N_PORTS-1:0] elig;
   logic [N_PORTS-1:0] pick;

   genvar gp;
   generate
      for (gp = 0; gp < N_PORTS; gp++) begin : g_port
         assign op_a[gp]    = req_op[gp*OP_W +: OP_W];
         assign wdat_a[gp]  = req_wdata[gp*DATA_W +: DATA_W];
         assign base_a[gp]  = req_base[gp*ADDR_W +: ADDR_W];
         assign hcnt_a[gp]  = req_hcnt[gp*CNT_W +: CNT_W];
         assign vcnt_a[gp]  = req_vcnt[gp*CNT_W +: CNT_W];
         assign width_a[gp] = req_width[gp*CNT_W +: CNT_W];
         assign hlen_a[gp]  = req_hlen[gp*CNT_W +: CNT_W];
         assign vlen_a[gp]  = req_vlen[gp*CNT_W +: CNT_W];
         assign act_v[gp]   = op_is_valid(op_a[gp]);
         assign rd_mask[gp] = op_is_read(op_a[gp]);
      end
   endgenerate

   // refresh blocks every requester before arbitration
   assign elig = act_v & {N_PORTS{~refresh_busy}};

   gma_prio_pick #(.N(N_PORTS)) u_pick (
      .req  (elig),
      .pick (pick)
   );

   // one shared address generator behind the request mux
   logic [OP_W-1:0]   s_op;
   logic [DATA_W-1:0] s_wdat;
   logic [ADDR_W-1:0] s_base;
   logic [CNT_W-1:0]  s_hcnt, s_vcnt, s_width, s_hlen, s_vlen;

   always_comb begin
      s_op    = '0;
      s_wdat  = '0;
      s_base  = '0;
      s_hcnt  = '0;
      s_vcnt  = '0;
      s_width = '0;
      s_hlen  = '0;
      s_vlen  = '0;
      for (int p = 0; p < N_PORTS; p++) begin
         if (pick[p]) begin
            s_op    |= op_a[p];
            s_wdat  |= wdat_a[p];
            s_base  |= base_a[p];
            s_hcnt  |= hcnt_a[p];
            s_vcnt  |= vcnt_a[p];
            s_width |= width_a[p];
            s_hlen  |= hlen_a[p];
            s_vlen  |= vlen_a[p];
         end
      end
   end

   logic [ADDR_W-1:0] s_addr;
   logic              s_last;

   gma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_agen (
      .op    (s_op),
      .base  (s_base),
      .hcnt  (s_hcnt),
      .vcnt  (s_vcnt),
      .width (s_width),
      .hlen  (s_hlen),
      .vlen  (s_vlen),
      .addr  (s_addr),
      .last  (s_last)
   );

   logic any_pick;
   assign any_pick  = |pick;
   assign word_ack  = pick;
   assign word_done = pick & {N_PORTS{s_last}};

   gma_mem_model #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .en    (any_pick),
      .we    (op_is_write(s_op)),
      .addr  (s_addr[MEM_AW-1:0]),
      .wdata (s_wdat),
      .rdata (rd_data)
   );

   logic [N_PORTS-1:0] owner_q;
   logic [N_PORTS-1:0] rvld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= '0;
         rvld_q  <= '0;
      end else begin
         rvld_q <= pick & rd_mask;
         if (any_pick) begin
            owner_q <= s_last ? '0 : pick;
         end
      end
   end

   assign bus_gnt  = owner_q;
   assign rd_valid = rvld_q;

   // R3: no acknowledged port has a higher-priority valid request beside it
   generate
      for (gp = 1; gp < N_PORTS; gp++) begin : g_prio_chk
         a_r3_priority: assert property (@(posedge clk) disable iff (!rst_n)
            word_ack[gp] |-> !(|act_v[gp-1:0]));
      end
   endgenerate

   a_r3_ack_when_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!refresh_busy && (|act_v)) |-> (|word_ack));

   a_r7_refresh_stall: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_busy |-> (word_ack == '0));

   a_r7_gnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ack == '0) |=> $stable(bus_gnt));

   a_r8_take: assert property (@(posedge clk) disable iff (!rst_n)
      ((|word_ack) && (word_done == '0)) |=> (bus_gnt == $past(word_ack)));

   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (|word_done) |=> (bus_gnt == '0));

   a_r9_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done & ~word_ack) == '0);

   a_r6_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (|(word_ack & rd_mask)) |=> (rd_valid == $past(word_ack)));
endmodule

// File: tb/tb_gfx_mem_arbiter.sv
module tb_gfx_mem_arbiter;
   localparam int NP = 5;
   localparam int AW = 23;
   localparam int DW = 16;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic refresh_busy = 1'b0;

   logic [3:0]    b_op   [NP];
   logic [DW-1:0] b_wd   [NP];
   logic [AW-1:0] b_base [NP];
   logic [CW-1:0] b_h [NP], b_v [NP], b_w [NP], b_hl [NP], b_vl [NP];

   logic [NP*4-1:0]  req_op;
   logic [NP*DW-1:0] req_wdata;
   logic [NP*AW-1:0] req_base;
   logic [NP*CW-1:0] req_hcnt, req_vcnt, req_width, req_hlen, req_vlen;

   logic [NP-1:0] word_ack, word_done, bus_gnt, rd_valid;
   logic [DW-1:0] rd_data;

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         req_op[p*4 +: 4]      = b_op[p];
         req_wdata[p*DW +: DW] = b_wd[p];
         req_base[p*AW +: AW]  = b_base[p];
         req_hcnt[p*CW +: CW]  = b_h[p];
         req_vcnt[p*CW +: CW]  = b_v[p];
         req_width[p*CW +: CW] = b_w[p];
         req_hlen[p*CW +: CW]  = b_hl[p];
         req_vlen[p*CW +: CW]  = b_vl[p];
      end
   end

   gfx_mem_arbiter #(.N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .MEM_AW(10)) dut (
      .clk(clk), .rst_n(rst_n), .refresh_busy(refresh_busy),
      .req_op(req_op), .req_wdata(req_wdata), .req_base(req_base),
      .req_hcnt(req_hcnt), .req_vcnt(req_vcnt), .req_width(req_width),
      .req_hlen(req_hlen), .req_vlen(req_vlen),
      .word_ack(word_ack), .word_done(word_done), .bus_gnt(bus_gnt),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_ports();
      for (int p = 0; p < NP; p++) begin
         b_op[p] = 4'd0; b_wd[p] = '0; b_base[p] = '0;
         b_h[p] = '0; b_v[p] = '0; b_w[p] = '0; b_hl[p] = '0; b_vl[p] = '0;
      end
      refresh_busy = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      clear_ports();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // single write through port p; fields other than base set to junk (R5)
   task automatic wr_word(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit rfsh, input string tag);
      @(negedge clk);
      clear_ports();
      b_op[p] = 4'd2; b_base[p] = a; b_wd[p] = d;
      b_h[p] = 16'd5; b_v[p] = 16'd7; b_w[p] = 16'd9; b_hl[p] = 16'd3; b_vl[p] = 16'd2;
      refresh_busy = rfsh;
      #1;
      chk({tag, " ack"}, 32'(word_ack), rfsh ? 32'd0 : 32'(1 << p));
      chk({tag, " done"}, 32'(word_done), rfsh ? 32'd0 : 32'(1 << p));
   endtask

   task automatic rd_word(input int p, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input string tag);
      @(negedge clk);
      clear_ports();
      b_op[p] = 4'd1; b_base[p] = a;
      b_h[p] = 16'd11; b_v[p] = 16'd3; b_w[p] = 16'd40; b_hl[p] = 16'd2; b_vl[p] = 16'd2;
      #1;
      chk({tag, " read ack"}, 32'(word_ack), 32'(1 << p));
      @(negedge clk);
      clear_ports();
      #1;
      chk({tag, " rd_valid"}, 32'(rd_valid), 32'(1 << p));
      chk({tag, " rd_data"}, 32'(rd_data), 32'(exp));
   endtask

   // {op p4,p3,p2,p1,p0, expected ack, expected done}
   localparam logic [29:0] VEC [8] = '{
      {4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 5'b00000},
      {4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 5'b10000, 5'b10000},
      {4'h3, 4'h0, 4'h4, 4'h0, 4'h0, 5'b00100, 5'b00000},
      {4'h0, 4'h2, 4'h0, 4'h0, 4'hF, 5'b01000, 5'b01000},
      {4'h9, 4'h8, 4'h7, 4'h6, 4'h5, 5'b00000, 5'b00000},
      {4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 5'b00001, 5'b00000},
      {4'h0, 4'h4, 4'h0, 4'h1, 4'h0, 5'b00010, 5'b00010},
      {4'h4, 4'h0, 4'h3, 4'hF, 4'h0, 5'b00100, 5'b00000}
   };

   function automatic logic [DW-1:0] dat3(input int h, input int v);
      return 16'hA000 | DW'(v << 4) | DW'(h);
   endfunction
   function automatic logic [DW-1:0] dat1(input int h, input int v);
      return 16'hB000 | DW'(v << 4) | DW'(h);
   endfunction

   task automatic burst_test();
      int h3 = 0, v3 = 0, h1 = 0, v1 = 0;
      bit d3 = 0, d1 = 0;
      int n3 = 0, n1 = 0, preempt = 0;
      logic [NP-1:0] exp_own = '0;
      for (int cyc = 0; cyc < 80 && !(d3 && d1); cyc++) begin
         @(negedge clk);
         chk("R8 grant follows last ack", 32'(bus_gnt), 32'(exp_own));
         clear_ports();
         refresh_busy = (cyc == 2) || (cyc == 9);
         if (!d3) begin
            b_op[3] = 4'd4; b_base[3] = 23'd100; b_w[3] = 16'd20; b_hl[3] = 16'd4; b_vl[3] = 16'd3;
            b_h[3] = CW'(h3); b_v[3] = CW'(v3); b_wd[3] = dat3(h3, v3);
         end
         if (!d1 && cyc >= 5) begin
            b_op[1] = 4'd4; b_base[1] = 23'd400; b_w[1] = 16'd10; b_hl[1] = 16'd3; b_vl[1] = 16'd2;
            b_h[1] = CW'(h1); b_v[1] = CW'(v1); b_wd[1] = dat1(h1, v1);
         end
         #1;
         if (refresh_busy) chk("R7 no ack during refresh", 32'(word_ack), 32'd0);
         if (word_ack[1] && exp_own == 5'b01000) preempt++;
         if (word_ack[3]) begin
            n3++;
            chk("R9 done on last word p3", 32'(word_done[3]), 32'(h3 == 3 && v3 == 2));
            if (h3 == 3 && v3 == 2) d3 = 1;
            if (h3 == 3) begin h3 = 0; v3++; end else h3++;
         end
         if (word_ack[1]) begin
            n1++;
            chk("R9 done on last word p1", 32'(word_done[1]), 32'(h1 == 2 && v1 == 1));
            if (h1 == 2 && v1 == 1) d1 = 1;
            if (h1 == 2) begin h1 = 0; v1++; end else h1++;
         end
         if (word_ack != '0) exp_own = (word_done != '0) ? '0 : word_ack;
      end
      @(negedge clk);
      chk("R8 grant released after done", 32'(bus_gnt), 32'd0);
      clear_ports();
      chk("R10 p3 word count", 32'(n3), 32'd12);
      chk("R10 p1 word count", 32'(n1), 32'd6);
      chk("R8 preemption seen", 32'(preempt), 32'd1);
      for (int v = 0; v < 3; v++)
         for (int h = 0; h < 4; h++)
            rd_word(2, 23'(100 + h + v * 20), dat3(h, v), "R4 R10 p3 rect");
      for (int v = 0; v < 2; v++)
         for (int h = 0; h < 3; h++)
            rd_word(4, 23'(400 + h + v * 10), dat1(h, v), "R4 R10 p1 rect");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      clear_ports();
      do_reset();
      @(negedge clk);
      #1;
      chk("R1 reset gnt", 32'(bus_gnt), 32'd0);
      chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);
      chk("R1 reset ack", 32'(word_ack), 32'd0);
      chk("R1 reset done", 32'(word_done), 32'd0);

      // vector table: R2 codes, R3 priority, R9 done on singles
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         clear_ports();
         for (int p = 0; p < NP; p++) begin
            b_op[p] = VEC[i][10 + p*4 +: 4];
            b_base[p] = 23'(900 + 16 * p);
            b_w[p] = 16'd8; b_hl[p] = 16'd2; b_vl[p] = 16'd1;
            b_wd[p] = DW'(16'h5000 + i);
         end
         #1;
         chk($sformatf("R2 R3 vector %0d ack", i), 32'(word_ack), 32'(VEC[i][9:5]));
         chk($sformatf("R9 vector %0d done", i), 32'(word_done), 32'(VEC[i][4:0]));
      end

      do_reset();
      burst_test();

      // R5: single access ignores rectangle fields
      wr_word(4, 23'd60, 16'h3333, 1'b0, "R5 single write");
      rd_word(0, 23'd60, 16'h3333, "R5 single read at base");

      // R7: write during refresh leaves memory unchanged
      wr_word(0, 23'd50, 16'h1111, 1'b0, "R7 setup write");
      wr_word(0, 23'd50, 16'h2222, 1'b1, "R7 write under refresh");
      rd_word(3, 23'd50, 16'h1111, "R7 memory unchanged R6");

      // R4: address wraps to low memory bits (1024 words)
      wr_word(2, 23'd1030, 16'h4444, 1'b0, "R4 high address write");
      rd_word(1, 23'd6, 16'h4444, "R4 low-bit index");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule